// File: doc/BRIEF.md
# Split-Capable Serial Line Buffer

This block is the serial side of a dual-port video memory. It keeps one row image of the DRAM array, 256 words of 8 bits. A transfer request moves a whole row, or one half of a row, between the array and the buffer over a parallel row bus. Between transfers the buffer is streamed out or filled one word per serial step. The serial steps run apart from the random-access port. The serial direction comes from the type of the last transfer that was carried out. A read transfer selects output. A write or pseudo transfer selects input.

In split operation the buffer is used as two halves. The controller reloads or stores the idle half while the pointer is still walking through the other half. When the pointer reaches the last word of its half, it moves into the other half at a start tap that the split transfer saved. A status bit reports the half that holds the pointer, so the controller can schedule the next split transfer. A split request that aims at the half in use is held until the pointer leaves that half.

The serial clock is applied as a step strobe in the block's clock domain. The array side is a flat row bus. The row to read is presented on `row_rd_addr`, and the array answers combinationally on `row_rd_data`.

Top module: `vsam_line_buf`

## Requirements
- R1: After reset the pointer is 0, the buffer holds zeros, the serial mode is read, no full transfer is recorded, and `ser_oe`, `xfer_err`, `xfer_wait` and `row_wr_en` are all low.
- R2: A full read transfer (`xfer_kind`=0, `xfer_split`=0) loads all 256 words from `row_rd_data` (word i in bits i*8+7..i*8), sets the pointer to `xfer_tap` and selects read mode, all at the accepting edge.
- R3: Each `ser_step` without an accepted transfer advances the pointer by one, wrapping 255 to 0 outside split operation. `ser_dout` shows, one cycle later, the word the pointer addressed before the step.
- R4: `ser_oe` is registered as `ser_en` AND read mode. With `ser_en` low, serial writes are ignored, but the pointer still advances.
- R5: A full write (kind 1) or pseudo (kind 2 or 3) transfer selects write mode and sets the pointer to the tap. Only kind 1 pulses `row_wr_en` for one cycle, in the cycle after acceptance. During that pulse `row_wr_addr` is the request's row, `row_wr_half` is 2'b11, and `row_wr_data` is the buffer as it stood when the request was accepted.
- R6: In write mode a `ser_step` with `ser_en` high writes `ser_din` into the word at the pointer before the pointer advances.
- R7: A split transfer targets the half given by `xfer_tap[7]` (1 is words 128..255). A split read loads only that half. A split write stores with `row_wr_half` bit 1 for the upper half and bit 0 for the lower half. The pointer is not moved, `xfer_tap[6:0]` is saved as the entry tap, and the mode follows the kind.
- R8: While split operation is active, a step from word 127 or 255 goes to the other half at the saved entry tap.
- R9: A split request made before any full transfer raises `xfer_err` for one cycle and changes neither the mode, nor the buffer, nor the pointer.
- R10: A split request whose target half holds the pointer is held, with `xfer_wait` high, and is carried out at the first edge at which the pointer is in the other half. Requests that arrive while one is held are dropped.
- R11: In a cycle where a transfer is accepted, `ser_step` is ignored. There is no write and no advance.
- R12: `ptr_upper` always equals bit 7 of `ser_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Transfer request strobe |
| xfer_kind | input | 2 | 0 read, 1 write, 2/3 pseudo |
| xfer_split | input | 1 | Half-row transfer |
| xfer_tap | input | 8 | Start tap; bit 7 picks the half for split |
| xfer_row | input | 9 | Array row of the request |
| row_rd_addr | output | 9 | Row the array must present |
| row_rd_data | input | 2048 | Row contents from the array |
| row_wr_en | output | 1 | Store pulse to the array |
| row_wr_addr | output | 9 | Row to store into |
| row_wr_half | output | 2 | Halves to store (bit1 upper, bit0 lower) |
| row_wr_data | output | 2048 | Buffer contents to store |
| ser_step | input | 1 | Serial clock strobe |
| ser_en | input | 1 | Serial port enable |
| ser_din | input | 8 | Serial write data |
| ser_dout | output | 8 | Serial read data |
| ser_oe | output | 1 | Serial output enable (low means high impedance) |
| ser_ptr | output | 8 | Current serial pointer |
| ptr_upper | output | 1 | Pointer is in the upper half |
| xfer_err | output | 1 | Split request rejected, no full transfer yet |
| xfer_wait | output | 1 | A split request is being held |

## Verification
A corrupted pointer, a wrong split entry tap, or a bad half-crossing shows on `ser_ptr` and `ptr_upper` at the very next edge. A stale or misloaded buffer word appears on `ser_dout` one cycle after the pointer reaches it in read mode. In write mode it appears on `row_wr_data` in the cycle after the next write transfer. A wrong mode bit flips `ser_oe` one cycle after the transfer that set it. A mishandled hold shows as `xfer_wait` staying up, or the held transfer taking effect on the wrong edge. The bench models all of this behaviourally and compares every output on every cycle.

// File: rtl/vsam_pkg.sv
package vsam_pkg;
  typedef enum logic [1:0] {
    XK_READ   = 2'd0,
    XK_WRITE  = 2'd1,
    XK_PSEUDO = 2'd2,
    XK_RSVD   = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/vsam_xfer_ctl.sv
module vsam_xfer_ctl
  import vsam_pkg::*;
#(
  parameter int AW = 8,
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    req_kind,
  input  logic          req_split,
  input  logic [AW-1:0] req_tap,
  input  logic [RW-1:0] req_row,
  input  logic          cur_upper,
  output logic          exec,
  output xfer_kind_e    c_kind,
  output logic          c_split,
  output logic [AW-1:0] c_tap,
  output logic [RW-1:0] c_row,
  output logic          mode_wr_q,
  output logic          split_on_q,
  output logic          err_q,
  output logic          pend_q
);
  xfer_kind_e    p_kind_q;
  logic          p_split_q;
  logic [AW-1:0] p_tap_q;
  logic [RW-1:0] p_row_q;
  logic          have_full_q;
  logic          cand, bad, block;

  // a held request wins over a fresh one; the fresh one is dropped
  always_comb begin
    cand    = pend_q | req;
    c_kind  = pend_q ? p_kind_q  : xfer_kind_e'(req_kind);
    c_split = pend_q ? p_split_q : req_split;
    c_tap   = pend_q ? p_tap_q   : req_tap;
    c_row   = pend_q ? p_row_q   : req_row;
    bad     = cand & c_split & ~have_full_q;
    block   = cand & c_split & have_full_q & (c_tap[AW-1] == cur_upper);
    exec    = cand & ~bad & ~block;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      have_full_q <= 1'b0;
      mode_wr_q   <= 1'b0;
      split_on_q  <= 1'b0;
      err_q       <= 1'b0;
      p_kind_q    <= XK_READ;
      p_split_q   <= 1'b0;
      p_tap_q     <= '0;
      p_row_q     <= '0;
    end else begin
      err_q  <= bad;
      pend_q <= block;
      if (block) begin
        p_kind_q  <= c_kind;
        p_split_q <= c_split;
        p_tap_q   <= c_tap;
        p_row_q   <= c_row;
      end
      if (exec) begin
        mode_wr_q  <= (c_kind != XK_READ);
        split_on_q <= c_split;
        if (!c_split) have_full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsam_ptr.sv
module vsam_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_full,
  input  logic          load_split,
  input  logic [AW-1:0] tap,
  input  logic          step,
  input  logic          split_on,
  output logic [AW-1:0] ptr_q,
  output logic          upper_q
);
  logic [AW-2:0] entry_q;
  logic [AW-1:0] nxt;
  logic          at_end;

  always_comb begin
    at_end = &ptr_q[AW-2:0];
    nxt    = ptr_q;
    if (load_full)
      nxt = tap;
    else if (step)
      nxt = (split_on && at_end) ? {~ptr_q[AW-1], entry_q} : ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      upper_q <= 1'b0;
      entry_q <= '0;
    end else begin
      ptr_q   <= nxt;
      upper_q <= nxt[AW-1];
      if (load_split) entry_q <= tap[AW-2:0];
    end
  end
endmodule

// File: rtl/vsam_store.sv
module vsam_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_lower,
  input  logic                       ld_upper,
  input  logic [(1<<AW)*DW-1:0]      row_in,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_q,
  output logic [(1<<AW)*DW-1:0]      row_out
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rd_q <= '0;
    end else begin
      rd_q <= mem_q[rd_addr];
      for (int i = 0; i < DEPTH; i++) begin
        if ((i >= HALF) ? ld_upper : ld_lower)
          mem_q[i] <= row_in[i*DW +: DW];
        else if (wr_en && wr_addr == AW'(i))
          mem_q[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign row_out[g*DW +: DW] = mem_q[g];
  end
endmodule

// File: rtl/vsam_line_buf.sv
module vsam_line_buf
  import vsam_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int RW = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     xfer_req,
  input  logic [1:0]               xfer_kind,
  input  logic                     xfer_split,
  input  logic [AW-1:0]            xfer_tap,
  input  logic [RW-1:0]            xfer_row,
  output logic [RW-1:0]            row_rd_addr,
  input  logic [(1<<AW)*DW-1:0]    row_rd_data,
  output logic                     row_wr_en,
  output logic [RW-1:0]            row_wr_addr,
  output logic [1:0]               row_wr_half,
  output logic [(1<<AW)*DW-1:0]    row_wr_data,
  input  logic                     ser_step,
  input  logic                     ser_en,
  input  logic [DW-1:0]            ser_din,
  output logic [DW-1:0]            ser_dout,
  output logic                     ser_oe,
  output logic [AW-1:0]            ser_ptr,
  output logic                     ptr_upper,
  output logic                     xfer_err,
  output logic                     xfer_wait
);
  logic          exec, c_split, mode_wr, split_on;
  xfer_kind_e    c_kind;
  logic [AW-1:0] c_tap;
  logic [RW-1:0] c_row;
  logic          is_rd, ld_lo, ld_up, step_ok, swr;

  vsam_xfer_ctl #(.AW(AW), .RW(RW)) ctl_i (
    .clk(clk), .rst(rst), .req(xfer_req), .req_kind(xfer_kind),
    .req_split(xfer_split), .req_tap(xfer_tap), .req_row(xfer_row),
    .cur_upper(ptr_upper), .exec(exec), .c_kind(c_kind), .c_split(c_split),
    .c_tap(c_tap), .c_row(c_row), .mode_wr_q(mode_wr), .split_on_q(split_on),
    .err_q(xfer_err), .pend_q(xfer_wait)
  );

  always_comb begin
    is_rd   = exec & (c_kind == XK_READ);
    ld_lo   = is_rd & (~c_split | ~c_tap[AW-1]);
    ld_up   = is_rd & (~c_split |  c_tap[AW-1]);
    step_ok = ser_step & ~exec;
    swr     = step_ok & ser_en & mode_wr;
  end

  assign row_rd_addr = c_row;

  vsam_ptr #(.AW(AW)) ptr_i (
    .clk(clk), .rst(rst), .load_full(exec & ~c_split),
    .load_split(exec & c_split), .tap(c_tap), .step(step_ok),
    .split_on(split_on), .ptr_q(ser_ptr), .upper_q(ptr_upper)
  );

  vsam_store #(.DW(DW), .AW(AW)) store_i (
    .clk(clk), .rst(rst), .ld_lower(ld_lo), .ld_upper(ld_up),
    .row_in(row_rd_data), .wr_en(swr), .wr_addr(ser_ptr), .wr_data(ser_din),
    .rd_addr(ser_ptr), .rd_q(ser_dout), .row_out(row_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_oe      <= 1'b0;
      row_wr_en   <= 1'b0;
      row_wr_addr <= '0;
      row_wr_half <= 2'b00;
    end else begin
      ser_oe    <= ser_en & ~mode_wr;
      row_wr_en <= exec & (c_kind == XK_WRITE);
      if (exec && c_kind == XK_WRITE) begin
        row_wr_addr <= c_row;
        row_wr_half <= c_split ? (c_tap[AW-1] ? 2'b10 : 2'b01) : 2'b11;
      end
    end
  end
endmodule

// File: rtl/vsam_line_buf_chk.sv
module vsam_line_buf_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_req,
  input logic          ser_step,
  input logic          ser_en,
  input logic          ser_oe,
  input logic [AW-1:0] ser_ptr,
  input logic          ptr_upper,
  input logic          xfer_err,
  input logic          xfer_wait,
  input logic          row_wr_en,
  input logic [1:0]    row_wr_half
);
  logic seen_q;
  always_ff @(posedge clk) seen_q <= rst ? 1'b0 : 1'b1;

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(ser_step) && !$past(xfer_req) && !$past(xfer_wait)) |-> $stable(ser_ptr));

  assert_oe_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && ser_oe) |-> $past(ser_en));

  assert_store_mask_R5: assert property (@(posedge clk) disable iff (rst)
    row_wr_en |-> (row_wr_half != 2'b00));

  assert_err_not_held_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_err |-> !xfer_wait);

  assert_half_flag_R12: assert property (@(posedge clk) disable iff (rst)
    ptr_upper == ser_ptr[AW-1]);
endmodule

bind vsam_line_buf vsam_line_buf_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .xfer_req(xfer_req), .ser_step(ser_step),
  .ser_en(ser_en), .ser_oe(ser_oe), .ser_ptr(ser_ptr), .ptr_upper(ptr_upper),
  .xfer_err(xfer_err), .xfer_wait(xfer_wait), .row_wr_en(row_wr_en),
  .row_wr_half(row_wr_half)
);

// File: tb/vsam_line_buf_tb_top.sv
module vsam_line_buf_tb_top;
  localparam int DW = 8, AW = 8, RW = 9, DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_req = 0, xfer_split = 0, ser_step = 0, ser_en = 0;
  logic [1:0] xfer_kind = 0;
  logic [AW-1:0] xfer_tap = 0;
  logic [RW-1:0] xfer_row = 0;
  logic [DW-1:0] ser_din = 0;
  logic [RW-1:0] row_rd_addr;
  logic [DEPTH*DW-1:0] row_rd_data, row_wr_data;
  logic row_wr_en, ser_oe, ptr_upper, xfer_err, xfer_wait;
  logic [RW-1:0] row_wr_addr;
  logic [1:0] row_wr_half;
  logic [DW-1:0] ser_dout;
  logic [AW-1:0] ser_ptr;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arr_word(int r, int i);
    return 8'(r * 37 + i * 5 + 3);
  endfunction

  always_comb
    for (int i = 0; i < DEPTH; i++) row_rd_data[i*DW +: DW] = arr_word(int'(row_rd_addr), i);

  vsam_line_buf dut_i (.*);

  // ---------------- behavioural reference ----------------
  logic [7:0] m_buf [DEPTH];
  logic [7:0] m_wdata [DEPTH];
  logic [7:0] m_ptr, m_dout;
  logic [6:0] m_entry;
  logic m_mode_wr, m_full, m_split, m_pend, m_err, m_oe, m_wen;
  logic [1:0] p_kind, m_whalf;
  logic p_split;
  logic [7:0] p_tap;
  logic [8:0] p_row, m_waddr;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m_buf[i] = 0;
      m_ptr = 0; m_dout = 0; m_entry = 0; m_mode_wr = 0; m_full = 0; m_split = 0;
      m_pend = 0; m_err = 0; m_oe = 0; m_wen = 0; m_waddr = 0; m_whalf = 0;
      p_kind = 0; p_split = 0; p_tap = 0; p_row = 0;
    end else begin
      logic cv, cs, bad, blk, ex;
      logic [1:0] ck;
      logic [7:0] ct;
      logic [8:0] cr;
      m_dout = m_buf[m_ptr];
      m_oe   = ser_en & ~m_mode_wr;
      cv = m_pend | xfer_req;
      ck = m_pend ? p_kind : xfer_kind;
      cs = m_pend ? p_split : xfer_split;
      ct = m_pend ? p_tap : xfer_tap;
      cr = m_pend ? p_row : xfer_row;
      bad = cv && cs && !m_full;
      blk = cv && cs && m_full && (ct[7] == m_ptr[7]);
      ex  = cv && !bad && !blk;
      m_wen = ex && ck == 2'd1;
      if (m_wen) begin
        for (int i = 0; i < DEPTH; i++) m_wdata[i] = m_buf[i];
        m_waddr = cr;
        m_whalf = cs ? (ct[7] ? 2'b10 : 2'b01) : 2'b11;
      end
      if (ser_step && !ex) begin
        if (ser_en && m_mode_wr) m_buf[m_ptr] = ser_din;
        if (m_split && m_ptr[6:0] == 7'h7f) m_ptr = {~m_ptr[7], m_entry};
        else m_ptr = m_ptr + 8'd1;
      end
      if (ex) begin
        if (ck == 2'd0)
          for (int i = 0; i < DEPTH; i++)
            if (!cs || (ct[7] == (i >= 128))) m_buf[i] = arr_word(int'(cr), i);
        m_mode_wr = (ck != 2'd0);
        if (!cs) begin m_full = 1; m_ptr = ct; end
        else m_entry = ct[6:0];
        m_split = cs;
      end
      if (blk) begin p_kind = ck; p_split = cs; p_tap = ct; p_row = cr; end
      m_pend = blk;
      m_err  = bad;
    end
  end

  // ---------------- comparison ----------------
  int total = 0, bad_cnt = 0;
  string tag = "R1";
  logic running = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s (%s phase %s): actual=%0h expected=%0h", req, what, tag, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk(ser_ptr == m_ptr, "R3", "ser_ptr", 64'(ser_ptr), 64'(m_ptr));
    chk(ptr_upper == m_ptr[7], "R12", "ptr_upper", 64'(ptr_upper), 64'(m_ptr[7]));
    chk(ser_oe == m_oe, "R4", "ser_oe", 64'(ser_oe), 64'(m_oe));
    chk(xfer_err == m_err, "R9", "xfer_err", 64'(xfer_err), 64'(m_err));
    chk(xfer_wait == m_pend, "R10", "xfer_wait", 64'(xfer_wait), 64'(m_pend));
    chk(row_wr_en == m_wen, "R5", "row_wr_en", 64'(row_wr_en), 64'(m_wen));
    if (m_oe) chk(ser_dout == m_dout, "R3", "ser_dout", 64'(ser_dout), 64'(m_dout));
    if (m_wen) begin
      int first_bad = -1;
      chk(row_wr_addr == m_waddr, "R5", "row_wr_addr", 64'(row_wr_addr), 64'(m_waddr));
      chk(row_wr_half == m_whalf, "R7", "row_wr_half", 64'(row_wr_half), 64'(m_whalf));
      for (int i = DEPTH - 1; i >= 0; i--)
        if (row_wr_data[i*DW +: DW] != m_wdata[i]) first_bad = i;
      chk(first_bad < 0, "R6", "row_wr_data word", 64'(first_bad < 0 ? 0 : row_wr_data[first_bad*DW +: DW]),
          64'(first_bad < 0 ? 0 : m_wdata[first_bad]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic rq, input logic [1:0] k, input logic sp, input logic [7:0] tp,
                     input logic [8:0] rw, input logic st, input logic en, input logic [7:0] d);
    @(negedge clk);
    xfer_req = rq; xfer_kind = k; xfer_split = sp; xfer_tap = tp; xfer_row = rw;
    ser_step = st; ser_en = en; ser_din = d;
  endtask

  task automatic steps(input int n, input logic en, input int seed);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, en, 8'(seed + i * 11));
    cyc(0, 0, 0, 0, 0, 0, en, 0);
  endtask

  task automatic xfer(input logic [1:0] k, input logic sp, input logic [7:0] tp, input logic [8:0] rw);
    cyc(1, k, sp, tp, rw, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  int cycles = 0;
  logic done = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++; bad_cnt++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk(ser_ptr == 0 && !ser_oe && !xfer_err && !xfer_wait && !row_wr_en, "R1", "reset outputs",
        64'({ser_ptr, ser_oe, xfer_err, xfer_wait, row_wr_en}), 64'(0));
    running = 1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    tag = "R9";  xfer(2'd0, 1, 8'h85, 9'd5);
    tag = "R2";  xfer(2'd0, 0, 8'd250, 9'd3);
    tag = "R3";  steps(12, 1, 0);
    tag = "R4";  steps(5, 0, 0);
    tag = "R11"; cyc(1, 2'd0, 0, 8'd10, 9'd4, 1, 1, 0); steps(4, 1, 0);
    tag = "R6";  xfer(2'd2, 0, 8'd0, 9'd0); steps(20, 1, 8'h40);
    tag = "R4";  steps(6, 0, 8'h99);
    tag = "R5";  xfer(2'd1, 0, 8'd0, 9'd7); steps(3, 1, 8'h10);
    tag = "R5";  xfer(2'd3, 0, 8'd30, 9'd8); steps(2, 1, 8'h20);
    tag = "R7";  xfer(2'd0, 0, 8'd100, 9'd1); steps(20, 1, 0);
                 xfer(2'd0, 1, 8'h85, 9'd2);
    tag = "R8";  steps(40, 1, 0);
    tag = "R10"; xfer(2'd0, 1, 8'h89, 9'd6);
                 xfer(2'd1, 0, 8'd0, 9'd9);
                 steps(260, 1, 0);
    tag = "R7";  xfer(2'd2, 0, 8'd0, 9'd0); steps(64, 1, 8'h33);
                 xfer(2'd1, 1, 8'h00, 9'd11);
                 steps(80, 1, 8'h55);
                 xfer(2'd1, 1, 8'h03, 9'd12);
                 steps(140, 1, 8'h66);
                 xfer(2'd1, 0, 8'd0, 9'd13);
    repeat (4) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    running = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end
endmodule